// File: doc/BRIEF.md
# Uniform Vector Component Alignment Scaler

This block brings the three unsigned magnitudes of a 3D vector into a narrow working range while keeping the vector's direction. Every component is multiplied by the same power of two, chosen so that afterwards no magnitude exceeds 2^15-1 and the largest one is at least 2^14. Narrower arithmetic downstream (squaring, root extraction, division) can then work on 15-bit operands instead of 32-bit ones.

The common shift is found from the OR of the three magnitudes: the highest set bit of that OR fixes how far everything moves. Right shifts drop the bits that fall off the bottom, so each result is at most one LSB below the exact scaled value. Left shifts are exact. Each component's sign flag bypasses the shifter unchanged. The chosen shift is exported as a signed count so later stages can undo the scaling. The block is one registered stage that takes a new vector every clock, with a valid bit travelling alongside and a stall input that freezes the stage.

Top module: `vnorm_align`

## Requirements
- R1: For a valid output whose magnitudes are not all zero, bit 14 is set in at least one of the three output magnitudes, and no output magnitude exceeds 2^15-1.
- R2: `out_shift` is a 6-bit two's complement count equal to p-14, where p is the index of the highest set bit among the three input magnitudes; positive means a right shift, negative a left shift, so it ranges from +17 (bit 31 set) to -14 (only bit 0 set).
- R3: When the shift count s is positive, each output magnitude equals the input magnitude divided by 2^s with the remainder discarded.
- R4: When the shift count s is negative, each output magnitude equals the input magnitude multiplied by 2^-s, exactly.
- R5: Each output sign flag equals the sign flag presented with the same vector.
- R6: An all-zero input vector gives all-zero output magnitudes and a shift count of 0.
- R7: A vector accepted on a clock edge with `stall` low appears at the outputs after that edge, with `out_valid` equal to the `in_valid` given with it.
- R8: While `stall` is high at a clock edge, every output keeps its value regardless of the inputs.
- R9: Synchronous active-high `rst` clears `out_valid`, all magnitudes, sign flags and the shift count.
- R10: All three components use one shift count, so their ratios are preserved (for example 2^20, 2^18, 2^16 become 16384, 4096, 1024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the stage when high |
| in_valid | input | 1 | Input vector is valid |
| in_mag_x | input | 32 | X magnitude, unsigned |
| in_mag_y | input | 32 | Y magnitude, unsigned |
| in_mag_z | input | 32 | Z magnitude, unsigned |
| in_neg_x | input | 1 | X sign flag (1 = negative) |
| in_neg_y | input | 1 | Y sign flag |
| in_neg_z | input | 1 | Z sign flag |
| out_valid | output | 1 | Output vector is valid |
| out_mag_x | output | 15 | Scaled X magnitude |
| out_mag_y | output | 15 | Scaled Y magnitude |
| out_mag_z | output | 15 | Scaled Z magnitude |
| out_neg_x | output | 1 | X sign flag, passed through |
| out_neg_y | output | 1 | Y sign flag, passed through |
| out_neg_z | output | 1 | Z sign flag, passed through |
| out_shift | output | 6 | Signed shift count, positive = right |

## Verification
The hardest situations to reach are the extreme shift counts, bit 31 forcing a right shift of 17 and a lone bit 0 forcing a left shift of 14, and the case where the leading bit sits in a component other than the first, since random 32-bit values almost always set one of the top few bits. The stimulus therefore sweeps the leading bit through all 32 positions, placing it in each of the three components in turn with random lower bits in all three, before adding wide-range random vectors whose magnitudes are pre-shifted by random amounts. Stall runs with changing inputs and a mid-run reset cover the hold and clear behaviour.

// File: rtl/vnorm_pkg.sv
package vnorm_pkg;
  localparam int unsigned VN_IN_W  = 32;
  localparam int unsigned VN_OUT_W = 15;

  // Direction decoded from the signed shift count
  typedef enum logic [1:0] {
    SH_HOLD = 2'd0,
    SH_DOWN = 2'd1,
    SH_UP   = 2'd2
  } shift_dir_e;
endpackage

// File: rtl/vnorm_lead_detect.sv
// Finds the highest set bit over the OR of all components and turns it
// into a signed shift count (positive = right).
module vnorm_lead_detect #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 15,
  parameter int NCOMP = 3,
  localparam int POS_W = $clog2(IN_W),
  localparam int SH_W  = POS_W + 1
) (
  input  logic [NCOMP-1:0][IN_W-1:0] mag,
  output logic signed [SH_W-1:0]     shift
);
  localparam logic signed [SH_W-1:0] BIAS = SH_W'(OUT_W - 1);

  logic [IN_W-1:0]  or_bits;
  logic [POS_W-1:0] pos;
  logic             any_set;

  always_comb begin
    or_bits = '0;
    for (int c = 0; c < NCOMP; c++) begin
      or_bits = or_bits | mag[c];
    end
  end

  // Ascending scan: the last hit is the most significant one.
  always_comb begin
    pos = '0;
    for (int b = 0; b < IN_W; b++) begin
      if (or_bits[b]) pos = POS_W'(b);
    end
  end

  assign any_set = |or_bits;
  assign shift   = any_set ? ($signed({1'b0, pos}) - BIAS) : '0;
endmodule

// File: rtl/vnorm_comp_shift.sv
// Moves one magnitude by the shared signed count and keeps OUT_W bits.
module vnorm_comp_shift
  import vnorm_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 15,
  parameter int SH_W  = 6
) (
  input  logic [IN_W-1:0]        mag,
  input  logic signed [SH_W-1:0] shift,
  output logic [OUT_W-1:0]       res
);
  shift_dir_e      dir;
  logic [SH_W-1:0] neg_amt;

  always_comb begin
    neg_amt = -shift;
    if (shift == '0)         dir = SH_HOLD;
    else if (shift[SH_W-1])  dir = SH_UP;
    else                     dir = SH_DOWN;

    unique case (dir)
      SH_DOWN: res = OUT_W'(mag >> $unsigned(shift));
      SH_UP:   res = OUT_W'(mag << neg_amt);
      default: res = OUT_W'(mag);
    endcase
  end
endmodule

// File: rtl/vnorm_align.sv
module vnorm_align #(
  parameter int IN_W  = vnorm_pkg::VN_IN_W,
  parameter int OUT_W = vnorm_pkg::VN_OUT_W,
  localparam int SH_W = $clog2(IN_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_mag_x,
  input  logic [IN_W-1:0]  in_mag_y,
  input  logic [IN_W-1:0]  in_mag_z,
  input  logic             in_neg_x,
  input  logic             in_neg_y,
  input  logic             in_neg_z,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_mag_x,
  output logic [OUT_W-1:0] out_mag_y,
  output logic [OUT_W-1:0] out_mag_z,
  output logic             out_neg_x,
  output logic             out_neg_y,
  output logic             out_neg_z,
  output logic [SH_W-1:0]  out_shift
);
  localparam int NCOMP = 3;

  logic [NCOMP-1:0][IN_W-1:0]  mag_in;
  logic [NCOMP-1:0][OUT_W-1:0] mag_nx;
  logic [NCOMP-1:0][OUT_W-1:0] mag_q;
  logic [NCOMP-1:0]            neg_in;
  logic [NCOMP-1:0]            neg_q;
  logic signed [SH_W-1:0]      shift_nx;
  logic [SH_W-1:0]             shift_q;
  logic                        valid_q;

  assign mag_in = {in_mag_z, in_mag_y, in_mag_x};
  assign neg_in = {in_neg_z, in_neg_y, in_neg_x};

  vnorm_lead_detect #(
    .IN_W (IN_W),
    .OUT_W(OUT_W),
    .NCOMP(NCOMP)
  ) u_detect (
    .mag  (mag_in),
    .shift(shift_nx)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    vnorm_comp_shift #(
      .IN_W (IN_W),
      .OUT_W(OUT_W),
      .SH_W (SH_W)
    ) u_shift (
      .mag  (mag_in[c]),
      .shift(shift_nx),
      .res  (mag_nx[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mag_q   <= '0;
      neg_q   <= '0;
      shift_q <= '0;
    end else if (!stall) begin
      valid_q <= in_valid;
      mag_q   <= mag_nx;
      neg_q   <= neg_in;
      shift_q <= shift_nx;
    end
  end

  assign out_valid = valid_q;
  assign out_mag_x = mag_q[0];
  assign out_mag_y = mag_q[1];
  assign out_mag_z = mag_q[2];
  assign out_neg_x = neg_q[0];
  assign out_neg_y = neg_q[1];
  assign out_neg_z = neg_q[2];
  assign out_shift = shift_q;
endmodule

// File: rtl/vnorm_align_chk.sv
module vnorm_align_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 15,
  localparam int SH_W = $clog2(IN_W) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_mag_x,
  input logic [IN_W-1:0]  in_mag_y,
  input logic [IN_W-1:0]  in_mag_z,
  input logic             in_neg_x,
  input logic             in_neg_y,
  input logic             in_neg_z,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_mag_x,
  input logic [OUT_W-1:0] out_mag_y,
  input logic [OUT_W-1:0] out_mag_z,
  input logic             out_neg_x,
  input logic             out_neg_y,
  input logic             out_neg_z,
  input logic [SH_W-1:0]  out_shift
);
  localparam logic signed [SH_W-1:0] SH_MAX = SH_W'(IN_W - OUT_W);
  localparam logic signed [SH_W-1:0] SH_MIN = -SH_W'(OUT_W - 1);

  // R1: a non-zero result always has its leading bit at the top position
  a_r1_top_bit_set: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ((out_mag_x | out_mag_y | out_mag_z) != '0)) |->
      (out_mag_x[OUT_W-1] | out_mag_y[OUT_W-1] | out_mag_z[OUT_W-1]));

  // R2: the count stays inside the legal window
  a_r2_shift_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(out_shift) <= SH_MAX) && ($signed(out_shift) >= SH_MIN));

  // R5: sign flags follow their vector
  a_r5_sign_pass: assert property (@(posedge clk) disable iff (rst)
    !stall |=> ({out_neg_z, out_neg_y, out_neg_x} ==
                $past({in_neg_z, in_neg_y, in_neg_x})));

  // R6: zero vector gives zero result and zero count
  a_r6_zero_vector: assert property (@(posedge clk) disable iff (rst)
    (!stall && ((in_mag_x | in_mag_y | in_mag_z) == '0)) |=>
      ((out_shift == '0) && ((out_mag_x | out_mag_y | out_mag_z) == '0)));

  // R7: valid travels with a one-cycle delay
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (out_valid == $past(in_valid)));

  // R8: stall freezes every output
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable({out_valid, out_mag_x, out_mag_y, out_mag_z,
                       out_neg_x, out_neg_y, out_neg_z, out_shift}));
endmodule

bind vnorm_align vnorm_align_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stall    (stall),
  .in_valid (in_valid),
  .in_mag_x (in_mag_x),
  .in_mag_y (in_mag_y),
  .in_mag_z (in_mag_z),
  .in_neg_x (in_neg_x),
  .in_neg_y (in_neg_y),
  .in_neg_z (in_neg_z),
  .out_valid(out_valid),
  .out_mag_x(out_mag_x),
  .out_mag_y(out_mag_y),
  .out_mag_z(out_mag_z),
  .out_neg_x(out_neg_x),
  .out_neg_y(out_neg_y),
  .out_neg_z(out_neg_z),
  .out_shift(out_shift)
);

// File: tb/tb_vnorm_align.sv
`timescale 1ns/1ps
module tb_vnorm_align;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_mag_x = '0, in_mag_y = '0, in_mag_z = '0;
  logic        in_neg_x = 1'b0, in_neg_y = 1'b0, in_neg_z = 1'b0;
  logic        out_valid;
  logic [14:0] out_mag_x, out_mag_y, out_mag_z;
  logic        out_neg_x, out_neg_y, out_neg_z;
  logic [5:0]  out_shift;

  always #4 clk = ~clk;  // 125 MHz

  vnorm_align dut (
    .clk(clk), .rst(rst), .stall(stall), .in_valid(in_valid),
    .in_mag_x(in_mag_x), .in_mag_y(in_mag_y), .in_mag_z(in_mag_z),
    .in_neg_x(in_neg_x), .in_neg_y(in_neg_y), .in_neg_z(in_neg_z),
    .out_valid(out_valid),
    .out_mag_x(out_mag_x), .out_mag_y(out_mag_y), .out_mag_z(out_mag_z),
    .out_neg_x(out_neg_x), .out_neg_y(out_neg_y), .out_neg_z(out_neg_z),
    .out_shift(out_shift)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit     e_valid;
  longint e_mag[3];
  bit     e_neg[3];
  int     e_shift;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lead_pos(input longint a, input longint b, input longint c);
    longint big = a;
    int p = -1;
    if (b > big) big = b;
    if (c > big) big = c;
    while (big > 0) begin
      big = big / 2;
      p++;
    end
    return p;
  endfunction

  task automatic compare(input string tag);
    longint act[3];
    act[0] = longint'(out_mag_x); act[1] = longint'(out_mag_y); act[2] = longint'(out_mag_z);
    chk(out_valid == e_valid, {tag, " valid R7"}, longint'(out_valid), longint'(e_valid));
    chk(int'($signed(out_shift)) == e_shift, {tag, " shift R2"},
        longint'($signed(out_shift)), longint'(e_shift));
    for (int c = 0; c < 3; c++) begin
      chk(act[c] == e_mag[c],
          {tag, (e_shift > 0) ? " mag R3" : (e_shift < 0) ? " mag R4" : " mag R2/R6"},
          act[c], e_mag[c]);
    end
    chk({out_neg_z, out_neg_y, out_neg_x} == {e_neg[2], e_neg[1], e_neg[0]}, {tag, " sign R5"},
        longint'({out_neg_z, out_neg_y, out_neg_x}), longint'({e_neg[2], e_neg[1], e_neg[0]}));
    if (e_valid && (e_mag[0] + e_mag[1] + e_mag[2]) != 0)
      chk((out_mag_x[14] | out_mag_y[14] | out_mag_z[14]) == 1'b1, {tag, " top bit R1"},
          longint'({out_mag_z[14], out_mag_y[14], out_mag_x[14]}), 1);
  endtask

  // drive one cycle (called just after a falling edge), update model, check
  task automatic step(input bit v, input longint mx, input longint my, input longint mz,
                      input bit nx, input bit ny, input bit nz, input bit st, input string tag);
    longint m[3];
    int p, s;
    m[0] = mx; m[1] = my; m[2] = mz;
    in_valid = v; stall = st;
    in_mag_x = 32'(mx); in_mag_y = 32'(my); in_mag_z = 32'(mz);
    in_neg_x = nx; in_neg_y = ny; in_neg_z = nz;
    @(posedge clk);
    if (rst) begin
      e_valid = 0; e_shift = 0;
      for (int c = 0; c < 3; c++) begin e_mag[c] = 0; e_neg[c] = 0; end
    end else if (!st) begin
      p = lead_pos(mx, my, mz);
      s = (p < 0) ? 0 : p - 14;
      e_valid = v; e_shift = s;
      e_neg[0] = nx; e_neg[1] = ny; e_neg[2] = nz;
      for (int c = 0; c < 3; c++) begin
        if (s >= 0) e_mag[c] = m[c] / (longint'(1) << s);
        else        e_mag[c] = m[c] * (longint'(1) << (-s));
      end
    end
    @(negedge clk);
    compare(st ? {tag, " stall R8"} : tag);
  endtask

  initial begin
    repeat (80000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint lead, lo[3];
    @(negedge clk);
    // R9: reset state
    rst = 1'b1;
    step(1, 32'hFFFF_FFFF, 5, 7, 1, 1, 1, 0, "reset R9");
    step(1, 32'h1234, 5, 7, 1, 0, 1, 0, "reset R9");
    rst = 1'b0;

    // R6: zero vector
    step(1, 0, 0, 0, 1, 0, 1, 0, "zero R6");

    // R10: shared count preserves ratios
    step(1, 64'd1 << 20, 64'd1 << 18, 64'd1 << 16, 0, 1, 0, 0, "ratio R10");
    chk(out_mag_x == 15'd16384 && out_mag_y == 15'd4096 && out_mag_z == 15'd1024,
        "ratio R10 literal", longint'({out_mag_x, out_mag_y, out_mag_z}),
        longint'({15'd16384, 15'd4096, 15'd1024}));

    // extremes: bit 31 and lone bit 0
    step(1, 32'hFFFF_FFFF, 32'h0001_FFFF, 0, 0, 0, 1, 0, "max right R3");
    chk(int'($signed(out_shift)) == 17, "extreme right R2", longint'($signed(out_shift)), 17);
    step(1, 0, 0, 1, 1, 1, 0, 0, "max left R4");
    chk(int'($signed(out_shift)) == -14, "extreme left R2", longint'($signed(out_shift)), -14);

    // sweep leading bit through every position and every component
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 3; c++) begin
        lead = longint'(1) << p;
        for (int k = 0; k < 3; k++) lo[k] = longint'($urandom) & (lead - 1);
        lo[c] = lo[c] | lead;
        step(1, lo[0], lo[1], lo[2], 1'($urandom), 1'($urandom), 1'($urandom), 0, "sweep");
      end
    end

    // R8: stall with changing inputs
    step(1, 32'h0040_0000, 3, 9, 1, 0, 0, 0, "prestall");
    for (int i = 0; i < 4; i++)
      step(1'($urandom), longint'($urandom), longint'($urandom), 5, 0, 1, 1, 1, "hold");
    step(0, 12345, 0, 1, 0, 0, 0, 0, "unstall R7");

    // random wide range with valid toggling and occasional stall
    for (int i = 0; i < 300; i++)
      step(1'($urandom), longint'($urandom >> ($urandom % 32)),
           longint'($urandom >> ($urandom % 32)), longint'($urandom >> ($urandom % 32)),
           1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0, "random");

    // mid-run reset
    rst = 1'b1;
    step(1, 999, 1, 2, 1, 1, 1, 0, "midreset R9");
    rst = 1'b0;
    step(1, 32'h8000_0000, 0, 0, 1, 0, 0, 0, "after reset R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule